// File: doc/BRIEF.md
# Branch Trace Buffer with Compression

This block keeps a short history of taken branches. Every branch event carries a source address, a destination address, a flag that marks branches closing a hardware loop, and the interrupt level in force. Events that pass the control gates are stored as source/destination pairs in a circular buffer of `DEPTH` entries, 16 by default. Software reads the history back through three word registers: control, status and trace data. The newest entry comes out first. The destination half is returned first, then the source half. The entry is removed only once its source half has been read.

Two optional folding modes keep the history compact. When a branch repeats the newest entry, or the entry just before it, the block marks that entry by setting its bit 0 and does not store the branch again. When the buffer is full, the block does one of two things, chosen by a control bit: it drops the oldest entry, or it refuses the branch and pulses an overflow exception request for the core to act on.

Top module: `branch_trace_buf`

## Requirements
- R1: A write to offset 0x000 loads the control register from `reg_wdata[4:0]`. A read of 0x000 returns those five bits with zeros above. Bit 0 is power, bit 1 is enable, bit 2 selects exception-on-full, bit 3 enables newest-entry folding and bit 4 enables second-newest folding. All bits reset to 0.
- R2: Writes to the status offset 0x004 and the data offset 0x100 change neither the control value nor the buffer contents.
- R3: A read of offset 0x004 returns the number of entries held, capped at 16. It reads 0 after reset.
- R4: A read of offset 0x100 on an empty buffer returns 0 and changes nothing. Otherwise reads alternate. One read returns the newest entry's destination and removes nothing. The next read returns that entry's source and removes the entry.
- R5: A branch is considered only when power and enable are both 1. Branches with the loop flag set, and branches at level 0, are never stored.
- R6: With exception-on-full clear, a branch arriving at a full buffer replaces the oldest entry. The count stays at `DEPTH`.
- R7: With exception-on-full set, a branch arriving at a full buffer at level 4 or above is not stored. `ovf_req` is then high for exactly the one cycle after the event edge.
- R8: With exception-on-full set, branches at levels 0 to 3 are neither stored nor able to raise `ovf_req`.
- R9: With newest-entry folding on and at least one entry held, a branch matching the newest entry is not stored. Instead, bit 0 of that entry's destination is set. The match compares both addresses with bit 0 ignored on both sides.
- R10: With second-newest folding on, at least two entries held and no newest-entry match, a branch matching the second-newest entry is not stored. Instead, bit 0 of that entry's source is set.
- R11: When a data read and a branch event fall in the same cycle, the read, including any removal, is applied first. The branch is then judged against the resulting contents and count.
- R12: A folded branch on a full buffer with exception-on-full clear discards nothing. With exception-on-full set, a full buffer raises the request before any fold check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data read pops on this edge |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 5 | Write data; only control bits exist |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the strobe cycle |
| ev_valid | input | 1 | Branch event present |
| ev_src | input | 32 | Branch source address |
| ev_dst | input | 32 | Branch destination address |
| ev_hwloop | input | 1 | Branch closes a hardware loop |
| ev_level | input | 4 | Current interrupt level, 0 is reset |
| ovf_req | output | 1 | One-cycle overflow exception request |

## Verification
The assertions assume that `reg_rd` and `reg_wr` do not both address the data register in a way that expects a write to take effect. They also assume `DEPTH` is a power of two, so that pointer wrap is a plain overflow. They take `ev_level` as meaningful only while `ev_valid` is high. The random stimulus draws addresses from a pool of four pairs, so that folds occur often. It sets bit 0 on some addresses to exercise the masked compare. It keeps the power and enable bits set most of the time, and it spreads levels over the whole 4-bit range so that the reset and low-level gates are exercised.

// File: rtl/brtrace_pkg.sv
// Shared definitions for the branch trace buffer.
// Assumes: control field layout is fixed; offsets are byte offsets.
package brtrace_pkg;
    localparam int CTRL_BITS = 5;
    localparam int ADDR_W    = 9;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT = 9'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA = 9'h100;

    // Packed so that power lands on bit 0 and second-newest folding on bit 4.
    typedef struct packed {
        logic fold2;
        logic fold1;
        logic exc_full;
        logic enable;
        logic power;
    } ctrl_t;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_STORE = 3'd1,
        ACT_FOLD1 = 3'd2,
        ACT_FOLD2 = 3'd3,
        ACT_OVF   = 3'd4
    } act_e;
endpackage

// File: rtl/brtrace_regs.sv
// Control register and offset decode.
// Assumes: reg_addr is a byte offset; unknown offsets select nothing.
module brtrace_regs
    import brtrace_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CTRL_BITS-1:0] reg_wdata,
    output ctrl_t                ctrl,
    output logic                 sel_ctrl,
    output logic                 sel_stat,
    output logic                 sel_data,
    output logic                 data_rd
);
    // Offset decode for the three registers.
    always_comb begin
        sel_ctrl = (reg_addr == OFS_CTRL);
        sel_stat = (reg_addr == OFS_STAT);
        sel_data = (reg_addr == OFS_DATA);
        data_rd  = reg_rd && sel_data;
    end

    // Control register: only writes at the control offset load it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (reg_wr && sel_ctrl)
            ctrl <= ctrl_t'(reg_wdata);
    end

    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL) |=> (ctrl == $past(reg_wdata)));
    assert_ctrl_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != OFS_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/brtrace_filter.sv
// Decides what to do with one branch event: nothing, store, fold into an
// existing entry, or request an overflow exception.
// Assumes: cnt, full and the entry views already reflect any same-cycle pop.
module brtrace_filter
    import brtrace_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LVL_W       = 4,
    parameter int EXC_LVL_MAX = 3,
    parameter int CNT_W       = 5
) (
    input  ctrl_t              ctrl,
    input  logic               ev_valid,
    input  logic [DATA_W-1:0]  ev_src,
    input  logic [DATA_W-1:0]  ev_dst,
    input  logic               ev_hwloop,
    input  logic [LVL_W-1:0]   ev_level,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               full,
    input  logic [DATA_W-1:0]  new_src,
    input  logic [DATA_W-1:0]  new_dst,
    input  logic [DATA_W-1:0]  old_src,
    input  logic [DATA_W-1:0]  old_dst,
    output act_e               act
);
    localparam logic [DATA_W-1:0] LSB = DATA_W'(1);
    localparam logic [LVL_W-1:0]  EXC_LVL = LVL_W'(EXC_LVL_MAX);

    logic gate, hit1, hit2;

    // Gate and address match terms; bit 0 is forced on both sides of each compare.
    always_comb begin
        gate = ev_valid && ctrl.power && ctrl.enable && !ev_hwloop &&
               (ev_level != '0) && !(ctrl.exc_full && ev_level <= EXC_LVL);
        hit1 = ctrl.fold1 && (cnt >= CNT_W'(1)) &&
               ((ev_src | LSB) == (new_src | LSB)) &&
               ((ev_dst | LSB) == (new_dst | LSB));
        hit2 = ctrl.fold2 && (cnt >= CNT_W'(2)) &&
               ((ev_src | LSB) == (old_src | LSB)) &&
               ((ev_dst | LSB) == (old_dst | LSB));
    end

    // Priority: exception on full first, then newest fold, second fold, store.
    always_comb begin
        if (!gate)                      act = ACT_NONE;
        else if (full && ctrl.exc_full) act = ACT_OVF;
        else if (hit1)                  act = ACT_FOLD1;
        else if (hit2)                  act = ACT_FOLD2;
        else                            act = ACT_STORE;
    end
endmodule

// File: rtl/brtrace_store.sv
// Circular storage with a write pointer, an entry count and a half flag.
// Pops are applied before the filter's action, which is judged on the
// post-pop view exported here.
// Assumes: DEPTH is a power of two; entry contents are not reset (an
// entry is never visible before it has been written).
module brtrace_store
    import brtrace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_rd,
    input  act_e               act,
    input  logic [DATA_W-1:0]  ev_src,
    input  logic [DATA_W-1:0]  ev_dst,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   cnt_post,
    output logic               full_post,
    output logic [DATA_W-1:0]  new_src,
    output logic [DATA_W-1:0]  new_dst,
    output logic [DATA_W-1:0]  old_src,
    output logic [DATA_W-1:0]  old_dst,
    output logic [DATA_W-1:0]  rd_value
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] src_mem [DEPTH];
    logic [DATA_W-1:0] dst_mem [DEPTH];
    logic [IDX_W-1:0]  top_ptr, ptr_post, idx_new, idx_old, idx_cur;
    logic              half, flip, pop;

    // Read sequencing: every non-empty data read flips the half; the source half pops.
    always_comb begin
        flip      = data_rd && (count != '0);
        pop       = flip && half;
        ptr_post  = pop ? top_ptr - IDX_W'(1) : top_ptr;
        cnt_post  = pop ? count - CNT_W'(1) : count;
        full_post = (cnt_post == CNT_FULL);
        idx_cur   = top_ptr - IDX_W'(1);
        idx_new   = ptr_post - IDX_W'(1);
        idx_old   = ptr_post - IDX_W'(2);
        new_src   = src_mem[idx_new];
        new_dst   = dst_mem[idx_new];
        old_src   = src_mem[idx_old];
        old_dst   = dst_mem[idx_old];
        rd_value  = (count == '0) ? '0 : (half ? src_mem[idx_cur] : dst_mem[idx_cur]);
    end

    // Pointer, count and half-flag update: pop first, then the event action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_ptr <= '0;
            count   <= '0;
            half    <= 1'b0;
        end else begin
            if (flip)
                half <= !half;
            top_ptr <= ptr_post;
            count   <= cnt_post;
            if (act == ACT_STORE) begin
                top_ptr <= ptr_post + IDX_W'(1);
                if (!full_post)
                    count <= cnt_post + CNT_W'(1);
            end
        end
    end

    // One write port per entry: full store, or a bit-0 mark for folding.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [IDX_W-1:0] ME = IDX_W'(g);
        // Entry g takes a new pair or gets its fold mark set.
        always_ff @(posedge clk) begin
            if (rst_n && act == ACT_STORE && ptr_post == ME) begin
                src_mem[g] <= ev_src;
                dst_mem[g] <= ev_dst;
            end else if (rst_n && act == ACT_FOLD1 && idx_new == ME) begin
                dst_mem[g][0] <= 1'b1;
            end else if (rst_n && act == ACT_FOLD2 && idx_old == ME) begin
                src_mem[g][0] <= 1'b1;
            end
        end
    end

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL);
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && count == '0 && act == ACT_NONE) |=> (count == '0 && $stable(half)));
    assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && count != '0 && half && act == ACT_NONE) |=>
            (count == $past(count) - CNT_W'(1)));
    assert_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STORE && full_post) |=> (count == CNT_FULL));
    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_OVF) |=> (count == $past(cnt_post)));
    assert_fold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_FOLD1 || act == ACT_FOLD2) |=> (count == $past(cnt_post)));
endmodule

// File: rtl/branch_trace_buf.sv
// Branch trace buffer top: register decode, event filter, storage and the
// registered overflow exception request.
// Assumes: one register access per cycle; DEPTH is a power of two.
module branch_trace_buf
    import brtrace_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int STAT_CAP    = 16,
    parameter int LVL_W       = 4,
    parameter int EXC_LVL_MAX = 3,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CTRL_BITS-1:0] reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 ev_valid,
    input  logic [DATA_W-1:0]    ev_src,
    input  logic [DATA_W-1:0]    ev_dst,
    input  logic                 ev_hwloop,
    input  logic [LVL_W-1:0]     ev_level,
    output logic                 ovf_req
);
    localparam logic [LVL_W-1:0] EXC_LVL = LVL_W'(EXC_LVL_MAX);

    ctrl_t             ctrl;
    logic              sel_ctrl, sel_stat, sel_data, data_rd, full_post;
    act_e              act;
    logic [CNT_W-1:0]  count, cnt_post;
    logic [DATA_W-1:0] new_src, new_dst, old_src, old_dst, rd_value, stat_val;

    brtrace_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl(ctrl),
        .sel_ctrl(sel_ctrl), .sel_stat(sel_stat), .sel_data(sel_data),
        .data_rd(data_rd)
    );

    brtrace_filter #(
        .DATA_W(DATA_W), .LVL_W(LVL_W), .EXC_LVL_MAX(EXC_LVL_MAX), .CNT_W(CNT_W)
    ) u_filter (
        .ctrl(ctrl), .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst),
        .ev_hwloop(ev_hwloop), .ev_level(ev_level), .cnt(cnt_post),
        .full(full_post), .new_src(new_src), .new_dst(new_dst),
        .old_src(old_src), .old_dst(old_dst), .act(act)
    );

    brtrace_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .act(act),
        .ev_src(ev_src), .ev_dst(ev_dst), .count(count), .cnt_post(cnt_post),
        .full_post(full_post), .new_src(new_src), .new_dst(new_dst),
        .old_src(old_src), .old_dst(old_dst), .rd_value(rd_value)
    );

    // Status value: entry count saturated at the reported cap.
    always_comb begin
        if (DATA_W'(count) > DATA_W'(STAT_CAP))
            stat_val = DATA_W'(STAT_CAP);
        else
            stat_val = DATA_W'(count);
    end

    // Read data mux by offset; unknown offsets read zero.
    always_comb begin
        if (sel_ctrl)      reg_rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl};
        else if (sel_stat) reg_rdata = stat_val;
        else if (sel_data) reg_rdata = rd_value;
        else               reg_rdata = '0;
    end

    // Exception request: one registered pulse per refused event.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_req <= 1'b0;
        else        ovf_req <= (act == ACT_OVF);
    end

    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.power || !ctrl.enable || ev_hwloop || ev_level == '0) |-> (act == ACT_NONE));
    assert_low_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.exc_full && ev_level <= EXC_LVL) |-> (act == ACT_NONE));
    assert_ovf_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_req |-> ($past(ctrl.exc_full) && $past(count) == CNT_W'(DEPTH)
                     || $past(cnt_post) == CNT_W'(DEPTH)));
    assert_exc_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.exc_full && full_post) |-> (act == ACT_NONE || act == ACT_OVF));
endmodule

// File: tb/branch_trace_buf_test.sv
`timescale 1ns/1ps
module branch_trace_buf_test;
    localparam logic [8:0] A_CTRL = 9'h000;
    localparam logic [8:0] A_STAT = 9'h004;
    localparam logic [8:0] A_DATA = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [4:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_valid = 1'b0, ev_hwloop = 1'b0;
    logic [31:0] ev_src = '0, ev_dst = '0;
    logic [3:0]  ev_level = '0;
    logic        ovf_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench reference state
    logic [31:0] m_src [16];
    logic [31:0] m_dst [16];
    int          m_top, m_cnt;
    bit          m_half;
    logic [4:0]  m_ctrl;

    always #2 clk = ~clk;

    branch_trace_buf uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst),
        .ev_hwloop(ev_hwloop), .ev_level(ev_level), .ovf_req(ovf_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        if (a == A_CTRL) return {27'd0, m_ctrl};
        if (a == A_STAT) return (m_cnt > 16) ? 32'd16 : 32'(m_cnt);
        if (a == A_DATA) begin
            if (m_cnt == 0) return 32'd0;
            return m_half ? m_src[(m_top - 1) & 15] : m_dst[(m_top - 1) & 15];
        end
        return 32'd0;
    endfunction

    function automatic bit same(input logic [31:0] a, input logic [31:0] b);
        return (a | 32'd1) == (b | 32'd1);
    endfunction

    // One cycle: drive, check read, update reference (pop, event, ctrl), check ovf_req.
    task automatic step(input string tag, input bit wr, input bit rd, input logic [8:0] a,
                        input logic [4:0] wd, input bit ev, input logic [31:0] s,
                        input logic [31:0] d, input bit hw, input logic [3:0] lvl);
        bit exp_ovf = 1'b0;
        int n, o;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        ev_valid = ev; ev_src = s; ev_dst = d; ev_hwloop = hw; ev_level = lvl;
        #1;
        if (rd) chk(tag, reg_rdata, exp_read(a));
        if (rd && a == A_DATA && m_cnt != 0) begin
            if (m_half) begin m_top = (m_top - 1) & 15; m_cnt--; end
            m_half = !m_half;
        end
        if (ev && m_ctrl[0] && m_ctrl[1] && !hw && lvl != 0 && !(m_ctrl[2] && lvl <= 3)) begin
            n = (m_top - 1) & 15;
            o = (m_top - 2) & 15;
            if (m_cnt == 16 && m_ctrl[2]) exp_ovf = 1'b1;
            else if (m_ctrl[3] && m_cnt >= 1 && same(s, m_src[n]) && same(d, m_dst[n]))
                m_dst[n][0] = 1'b1;
            else if (m_ctrl[4] && m_cnt >= 2 && same(s, m_src[o]) && same(d, m_dst[o]))
                m_src[o][0] = 1'b1;
            else begin
                m_src[m_top] = s; m_dst[m_top] = d;
                m_top = (m_top + 1) & 15;
                if (m_cnt < 16) m_cnt++;
            end
        end
        if (wr && a == A_CTRL) m_ctrl = wd;
        @(posedge clk); #1;
        chk("R7 ovf_req", {31'd0, ovf_req}, {31'd0, exp_ovf});
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; ev_valid = 0;
    endtask

    task automatic wctrl(input string tag, input logic [4:0] v);
        step(tag, 1, 0, A_CTRL, v, 0, 0, 0, 0, 0);
    endtask
    task automatic rd(input string tag, input logic [8:0] a);
        step(tag, 0, 1, a, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic br(input string tag, input logic [31:0] s, input logic [31:0] d,
                      input bit hw, input logic [3:0] lvl);
        step(tag, 0, 0, A_CTRL, 0, 1, s, d, hw, lvl);
    endtask
    task automatic drain(input string tag);
        while (m_cnt != 0) rd(tag, A_DATA);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_top = 0; m_cnt = 0; m_half = 0; m_ctrl = '0;
        for (int i = 0; i < 16; i++) begin m_src[i] = '0; m_dst[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R7 reset ovf", {31'd0, ovf_req}, 32'd0);
        rd("R1 reset ctrl", A_CTRL);
        rd("R3 reset status", A_STAT);
        rd("R4 reset data", A_DATA);

        // R1 / R2: control field width and ignored writes
        wctrl("R1", 5'h1F);
        rd("R1 ctrl readback", A_CTRL);
        step("R2", 1, 0, A_STAT, 5'h1F, 0, 0, 0, 0, 0);
        step("R2", 1, 0, A_DATA, 5'h00, 0, 0, 0, 0, 0);
        rd("R2 ctrl kept", A_CTRL);
        rd("R2 status kept", A_STAT);

        // R5: gating
        wctrl("R5", 5'h01);
        br("R5", 32'h100, 32'h200, 0, 5);
        rd("R5 power only", A_STAT);
        wctrl("R5", 5'h03);
        br("R5", 32'h100, 32'h200, 1, 5);
        br("R5", 32'h100, 32'h200, 0, 0);
        rd("R5 loop and level0", A_STAT);
        br("R5", 32'h100, 32'h200, 0, 5);
        rd("R5 stored", A_STAT);
        step("R2 data write", 1, 0, A_DATA, 0, 0, 0, 0, 0, 0);

        // R4: read halves then empty
        rd("R4 dst", A_DATA);
        rd("R4 src", A_DATA);
        rd("R4 empty", A_DATA);
        rd("R4 empty status", A_STAT);

        // R9: newest fold
        wctrl("R9", 5'h0B);
        br("R9", 32'h400, 32'h500, 0, 6);
        br("R9", 32'h401, 32'h500, 0, 6);
        rd("R9 count", A_STAT);
        rd("R9 dst mark", A_DATA);
        rd("R9 src", A_DATA);

        // R10: second-newest fold
        wctrl("R10", 5'h13);
        br("R10", 32'h10, 32'h20, 0, 7);
        br("R10", 32'h30, 32'h40, 0, 7);
        br("R10", 32'h10, 32'h20, 0, 7);
        rd("R10 count", A_STAT);
        drain("R10 contents");

        // R6: overwrite on full
        wctrl("R6", 5'h03);
        for (int i = 1; i <= 17; i++) br("R6", 32'(i * 16), 32'(i * 16 + 8), 0, 9);
        rd("R6 count", A_STAT);
        drain("R6 contents");

        // R7 / R8: exception on full
        wctrl("R7", 5'h07);
        for (int i = 1; i <= 16; i++) br("R7", 32'(i * 32), 32'(i * 32 + 4), 0, 9);
        br("R7 refuse", 32'h900, 32'h904, 0, 4);
        rd("R7 count", A_STAT);
        br("R8 low level", 32'h900, 32'h904, 0, 3);
        br("R8 low level", 32'h900, 32'h904, 0, 1);
        rd("R8 count", A_STAT);
        // R12: exception before fold
        wctrl("R12", 5'h0F);
        br("R12 exc first", 32'h200, 32'h204, 0, 8);
        // R12: fold on full with exception clear keeps oldest
        wctrl("R12", 5'h0B);
        br("R12 fold full", 32'h200, 32'h204, 0, 8);
        rd("R12 count", A_STAT);
        drain("R12 contents");

        // R11: pop and event in the same cycle
        wctrl("R11", 5'h0B);
        br("R11", 32'h600, 32'h700, 0, 5);
        rd("R11 dst", A_DATA);
        step("R11 pop+event", 0, 1, A_DATA, 0, 1, 32'h600, 32'h700, 0, 5);
        rd("R11 count", A_STAT);
        rd("R11 dst unfolded", A_DATA);
        rd("R11 src", A_DATA);

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            bit          ev = ($urandom % 10) < 6;
            int          p = $urandom % 4;
            logic [31:0] s = 32'h1000 + 32'(p) * 32'h40 + 32'($urandom % 2);
            logic [31:0] d = 32'h8000 + 32'(p) * 32'h80 + 32'($urandom % 2);
            bit          hw = ($urandom % 10) == 0;
            logic [3:0]  lv = 4'($urandom);
            int          r = $urandom % 100;
            if (r < 3)
                step("R1 random", 1, 0, A_CTRL, 5'($urandom) | 5'h03, ev, s, d, hw, lv);
            else if (r < 5)
                step("R2 random", 1, 0, (r == 3) ? A_STAT : A_DATA, 5'($urandom), ev, s, d, hw, lv);
            else if (r < 30)
                step("R4 random", 0, 1, A_DATA, 0, ev, s, d, hw, lv);
            else if (r < 38)
                step("R3 random", 0, 1, A_STAT, 0, ev, s, d, hw, lv);
            else if (r < 40)
                step("R1 random", 0, 1, A_CTRL, 0, ev, s, d, hw, lv);
            else
                step("R9 random", 0, 0, A_CTRL, 0, ev, s, d, hw, lv);
        end
        drain("R10 final drain");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule